// File: doc/BRIEF.md
# Two-Byte Converter Result Reader

This block sits on the host side of an 8-bit data bus and runs a 12-bit analog-to-digital converter in byte mode. When asked, it starts a full-length conversion with a single low cycle on the converter's read/convert line. It then watches the converter's busy flag until that flag falls.

Once the flag has fallen, the block fetches the result in two bus reads. The converter's byte-address input is driven like the least significant address bit, so the two bytes come from consecutive locations. The first read returns the eight most significant bits. The second returns the four least significant bits in the upper nibble, with zeros below them. A one-cycle idle gap separates the two reads.

The block rebuilds the left-justified 12-bit word from the two bytes and reports it with a one-cycle done strobe. A nonzero pad nibble in the second byte is flagged as a format error. The converter's word-width select is held at byte mode throughout.

Top module: `adc_byte_reader`

## Requirements
- R1: While reset is asserted and after it is released, the outputs are in their rest state: conv_rc high, chip_en low, chip_sel_n high, byte_addr low, done low, result zero and fmt_err low.
- R2: A start_req sampled high in the idle state drives conv_rc low for exactly one cycle, beginning the cycle after. In that cycle chip_en is high and chip_sel_n is low. Each accepted request yields exactly one such low cycle.
- R3: byte_addr is low in every cycle in which conv_rc is low, so the converter performs a full 12-bit conversion.
- R4: Reads begin only after conv_busy has been seen to go from high to low. A read is a cycle with chip_en high, chip_sel_n low and conv_rc high. No read happens while conv_busy is high.
- R5: The first read has byte_addr low. It is followed by exactly one cycle with chip_en low and chip_sel_n high. The second read, with byte_addr high, comes in the next cycle.
- R6: result equals {first byte[7:0], second byte[7:4]}. It is updated only at the second read and is valid in the cycle where done is high.
- R7: fmt_err is high exactly when bits [3:0] of the second byte are not all zero. It is updated together with result.
- R8: done is high for exactly one cycle, the cycle right after the second read.
- R9: start_req is ignored outside the idle state. Holding it high for a whole conversion produces no second conversion.
- R10: word_sel (the converter's 12/8 select) is always low, which selects byte-mode output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_req | input | 1 | Request one conversion and readout |
| conv_busy | input | 1 | Converter status flag, high while a conversion runs |
| bus_data | input | 8 | Data bus from the converter |
| conv_rc | output | 1 | Read/convert line, low for one cycle to start |
| chip_en | output | 1 | Converter chip enable, active high |
| chip_sel_n | output | 1 | Converter chip select, active low |
| byte_addr | output | 1 | Byte address bit to the converter (address LSB) |
| word_sel | output | 1 | Converter 12/8 select, held low |
| result | output | 12 | Rebuilt left-justified 12-bit result |
| fmt_err | output | 1 | Pad nibble of the second byte was nonzero |
| done | output | 1 | One-cycle strobe: result is valid |

## Verification
The hardest case to reach from the ports is a start request that is still held high while the block is between its two reads or in its done cycle. Only a converter model that answers the reads can keep the sequence moving into those states. The bench models the converter itself: it raises the busy flag for a variable number of cycles and serves bytes from a value it latched at the start. It holds start_req high across selected conversions and counts the low cycles on conv_rc. The sweep covers every 12-bit value and injects nonzero pad nibbles into some of the second bytes.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_WAIT  = 3'd2,
    ST_RD_HI = 3'd3,
    ST_GAP   = 3'd4,
    ST_RD_LO = 3'd5,
    ST_DONE  = 3'd6
  } rd_state_t;
endpackage

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
  import adc_rd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic conv_busy,
  output logic conv_rc,
  output logic chip_en,
  output logic chip_sel_n,
  output logic byte_addr,
  output logic cap_hi,
  output logic cap_lo,
  output logic done_pulse
);
  rd_state_t st, st_nx;
  logic busy_q;
  logic busy_fall;

  always_ff @(posedge clk) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= conv_busy;
  end

  assign busy_fall = busy_q & ~conv_busy;

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE:  if (start_req) st_nx = ST_START;
      ST_START: st_nx = ST_WAIT;
      ST_WAIT:  if (busy_fall) st_nx = ST_RD_HI;
      ST_RD_HI: st_nx = ST_GAP;
      ST_GAP:   st_nx = ST_RD_LO;
      ST_RD_LO: st_nx = ST_DONE;
      ST_DONE:  st_nx = ST_IDLE;
      default:  st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  always_comb begin
    conv_rc    = (st != ST_START);
    chip_en    = (st == ST_START) || (st == ST_RD_HI) || (st == ST_RD_LO);
    chip_sel_n = ~chip_en;
    byte_addr  = (st == ST_RD_LO);
    cap_hi     = (st == ST_RD_HI);
    cap_lo     = (st == ST_RD_LO);
    done_pulse = (st == ST_DONE);
  end

  assert_rc_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_rc) |=> conv_rc);
  assert_addr_low_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_rc |-> !byte_addr);
  assert_read_not_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_hi || cap_lo) |-> (conv_rc && !conv_busy));
  assert_gap_then_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hi |=> (!chip_en && chip_sel_n) ##1 (cap_lo && byte_addr));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);
  assert_done_after_lo_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_lo |=> done_pulse);
endmodule

// File: rtl/adc_rd_capture.sv
module adc_rd_capture #(
  parameter int BYTE_W = 8,
  parameter int RES_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_hi,
  input  logic              cap_lo,
  input  logic [BYTE_W-1:0] bus_data,
  output logic [RES_W-1:0]  result,
  output logic              fmt_err
);
  localparam int LO_W  = RES_W - BYTE_W;
  localparam int PAD_W = BYTE_W - LO_W;

  function automatic logic [RES_W-1:0] join_bytes(input logic [BYTE_W-1:0] hi,
                                                  input logic [BYTE_W-1:0] lo);
    return {hi, lo[BYTE_W-1 -: LO_W]};
  endfunction

  function automatic logic pad_bad(input logic [BYTE_W-1:0] lo);
    return |lo[PAD_W-1:0];
  endfunction

  logic [BYTE_W-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q    <= '0;
      result  <= '0;
      fmt_err <= 1'b0;
    end else begin
      if (cap_hi) hi_q <= bus_data;
      if (cap_lo) begin
        result  <= join_bytes(hi_q, bus_data);
        fmt_err <= pad_bad(bus_data);
      end
    end
  end

  assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_lo |=> ($stable(result) && $stable(fmt_err)));
  assert_hi_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_lo |=> (result[RES_W-1 -: BYTE_W] == $past(hi_q)));
endmodule

// File: rtl/adc_byte_reader.sv
module adc_byte_reader #(
  parameter int BYTE_W = 8,
  parameter int RES_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic              conv_busy,
  input  logic [BYTE_W-1:0] bus_data,
  output logic              conv_rc,
  output logic              chip_en,
  output logic              chip_sel_n,
  output logic              byte_addr,
  output logic              word_sel,
  output logic [RES_W-1:0]  result,
  output logic              fmt_err,
  output logic              done
);
  logic cap_hi;
  logic cap_lo;

  adc_rd_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_req  (start_req),
    .conv_busy  (conv_busy),
    .conv_rc    (conv_rc),
    .chip_en    (chip_en),
    .chip_sel_n (chip_sel_n),
    .byte_addr  (byte_addr),
    .cap_hi     (cap_hi),
    .cap_lo     (cap_lo),
    .done_pulse (done)
  );

  adc_rd_capture #(.BYTE_W(BYTE_W), .RES_W(RES_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_hi   (cap_hi),
    .cap_lo   (cap_lo),
    .bus_data (bus_data),
    .result   (result),
    .fmt_err  (fmt_err)
  );

  // R10: byte-mode output selected permanently
  assign word_sel = 1'b0;
endmodule

// File: tb/tb_adc_byte_reader.sv
`timescale 1ns/1ps
module tb_adc_byte_reader;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_req = 1'b0;
  logic conv_busy;
  logic [7:0] bus_data;
  logic conv_rc, chip_en, chip_sel_n, byte_addr, word_sel, fmt_err, done;
  logic [11:0] result;

  always #2 clk = ~clk;

  adc_byte_reader dut (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .conv_busy(conv_busy),
    .bus_data(bus_data), .conv_rc(conv_rc), .chip_en(chip_en),
    .chip_sel_n(chip_sel_n), .byte_addr(byte_addr), .word_sel(word_sel),
    .result(result), .fmt_err(fmt_err), .done(done)
  );

  int checks = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // converter model
  logic [11:0] conv_next = '0;
  logic [11:0] conv_val;
  logic [3:0]  nib_cur = '0;
  int busy_len = 1;
  int busy_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      conv_busy <= 1'b0;
      busy_cnt  <= 0;
      conv_val  <= '0;
    end else if (!conv_rc) begin
      conv_busy <= 1'b1;
      busy_cnt  <= busy_len;
      conv_val  <= conv_next;
    end else if (busy_cnt > 1) begin
      busy_cnt <= busy_cnt - 1;
    end else if (busy_cnt == 1) begin
      busy_cnt  <= 0;
      conv_busy <= 1'b0;
    end
  end

  always_comb begin
    if (chip_en && !chip_sel_n && conv_rc && !conv_busy)
      bus_data = byte_addr ? {conv_val[3:0], nib_cur} : conv_val[11:4];
    else
      bus_data = 8'hC3;
  end

  // protocol monitors
  int rc_lows = 0;
  int busy_reads = 0;
  int gap_errs = 0;
  logic p_en = 1'b0, p_rc = 1'b1, p_a0 = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!conv_rc) rc_lows <= rc_lows + 1;
      if (chip_en && conv_rc && conv_busy) busy_reads <= busy_reads + 1;
      if (chip_en && byte_addr && p_en) gap_errs <= gap_errs + 1;
      if (p_en && p_rc && !p_a0 && chip_en) gap_errs <= gap_errs + 1;
      p_en <= chip_en; p_rc <= conv_rc; p_a0 <= byte_addr;
    end
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic run_conv(input logic [11:0] v, input int blen,
                          input logic [3:0] nib, input bit hold);
    int lows0;
    bit got;
    @(negedge clk);
    conv_next = v; busy_len = blen; nib_cur = nib; start_req = 1'b1;
    lows0 = rc_lows;
    @(negedge clk);
    chk(!conv_rc && chip_en && !chip_sel_n, "R2", "start cycle rc/en",
        int'(conv_rc), 0);
    chk(!byte_addr, "R3", "addr at start", int'(byte_addr), 0);
    if (!hold) start_req = 1'b0;
    got = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (done) begin got = 1; break; end
    end
    chk(got, "R8", "done seen", int'(got), 1);
    chk(result == v, "R6", "result", int'(result), int'(v));
    chk(fmt_err == (nib != 0), "R7", "fmt_err", int'(fmt_err), int'(nib != 0));
    start_req = 1'b0;
    @(negedge clk);
    chk(!done, "R8", "done one cycle", int'(done), 0);
    repeat (3) @(negedge clk);
    chk(rc_lows == lows0 + 1, hold ? "R9" : "R2", "rc low cycles",
        rc_lows - lows0, 1);
  endtask

  initial begin : watchdog
    wait (cyc > 190000);
    fails++; checks++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(conv_rc && !chip_en && chip_sel_n && !byte_addr, "R1", "bus ctl at reset",
        {conv_rc, chip_en, chip_sel_n, byte_addr}, 4'b1010);
    chk(!done && result == 0 && !fmt_err, "R1", "result at reset",
        int'(result), 0);
    chk(!word_sel, "R10", "word_sel", int'(word_sel), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(conv_rc && !chip_en && chip_sel_n && !done, "R1", "after release",
        int'(chip_en), 0);

    for (int v = 0; v < 4096; v++) begin
      logic [3:0] nib;
      nib = (v % 9 == 0) ? 4'(1 + (v % 15)) : 4'd0;
      run_conv(12'(v), 1 + (v % 4), nib, (v % 11) == 0);
    end
    // edge patterns with long busy time
    run_conv(12'hFFF, 9, 4'hF, 1'b1);
    run_conv(12'h000, 7, 4'h0, 1'b0);
    run_conv(12'h801, 12, 4'h8, 1'b0);

    chk(busy_reads == 0, "R4", "reads while busy", busy_reads, 0);
    chk(gap_errs == 0, "R5", "gap violations", gap_errs, 0);
    chk(!word_sel, "R10", "word_sel at end", int'(word_sel), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule